// File: doc/BRIEF.md
# Atomic Swap Memory Target

This block is an on-chip memory target with one request port and one response port. It serves plain reads and writes, invalidate or upgrade requests, and atomic read-modify-write requests. All of these go to a window of `DEPTH*8` bytes that starts at address `BASE`. A request is accepted on every clock in which `reqValid` is high. There is no backpressure. Each request yields exactly one response after a fixed `LATENCY` clocks.

An atomic request always hands back the bytes that held the addressed location before the request. With `reqCond` low, it then stores the write operand unconditionally. With `reqCond` high, it stores the write operand only when the old value equals the compare operand. The response flag `rspSwapOk` tells the requester whether the store took place.

Memory is byte-addressed with little-endian byte lanes in 64-bit words. `BASE` must be a multiple of 8, and `DEPTH` must be a power of two. The memory state updates on the clock edge that samples a request, so the request that follows it sees the new contents.

Top module: `atomic_swap_mem`

## Requirements
- R1: A request whose bytes do not all lie in `[BASE, BASE+DEPTH*8)` responds with `rspErr`=1 and leaves memory unchanged.
- R2: `reqOp`=0 (read) and `reqOp`=1 (write) work at `reqSize` 0,1,2,3 = 1,2,4,8 bytes. Byte `k` of the data sits at address `reqAddr+k` (little-endian). Read data is right-justified and zero-extended. A write response carries `rspRdata`=0.
- R3: A request whose address is not a multiple of its byte count responds with `rspErr`=1 and leaves memory unchanged.
- R4: A write changes only the bytes it addresses. Neighbouring bytes in the same 64-bit word keep their values.
- R5: `reqOp`=3 with `reqCond`=0 returns the old value in `rspRdata`, stores the low bytes of `reqWdata`, and sets `rspSwapOk`=1, at any size.
- R6: `reqOp`=3 with `reqCond`=1 returns the old value. It stores `reqWdata` and sets `rspSwapOk`=1 only when the old value equals the low bytes of `reqCmp`. Otherwise memory is untouched and `rspSwapOk`=0.
- R7: `reqOp`=3 with `reqCond`=1 and `reqSize` 0 or 1 responds with `rspErr`=1 and writes nothing.
- R8: `reqOp`=2 (invalidate/upgrade) is acknowledged with `rspErr`=0, `rspRdata`=0 and `rspSwapOk`=0, and changes no memory byte.
- R9: Each request accepted on edge k produces `rspValid`=1 after edge k+LATENCY-1, including for back-to-back requests. No response appears without a request.
- R10: With `ZERO_INIT`=1, every byte reads as zero after reset.
- R11: During reset all response outputs are 0. An error response carries `rspRdata`=0 and `rspSwapOk`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 read, 1 write, 2 invalidate, 3 atomic swap |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | log2 of byte count |
| reqWdata | input | 64 | Write / swap operand, low bytes used |
| reqCmp | input | 64 | Compare operand for conditional swap |
| reqCond | input | 1 | Swap is conditional |
| rspValid | output | 1 | Response present |
| rspRdata | output | 64 | Read or old data, right-justified |
| rspErr | output | 1 | Request rejected |
| rspSwapOk | output | 1 | Atomic store took place |

## Verification
The bench goes after accesses that end exactly at the window top, or start one byte below the base. A wrong bound test would either reject the last legal doubleword or let a store wrap into the array. Conditional swaps at sizes 1 and 2 must be rejected. A design that falls through to a compare would write memory and report success. Back-to-back swaps to one address check that the second request sees the first one's store. A design that reads a stale word would return the pre-swap value twice. Partial writes followed by a full-word read expose lane-merge bugs that clobber neighbouring bytes.

// File: rtl/atomic_swap_mem_pkg.sv
package atomic_swap_mem_pkg;

  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_INVAL = 2'd2,
    OP_SWAP  = 2'd3
  } op_e;

  // Control-to-datapath strobes for the request being sampled this cycle.
  typedef struct packed {
    logic       valid;
    logic       err;
    logic       load;
    logic       store;
    logic       cmpGate;
    logic       isSwap;
    logic [2:0] laneOff;
    logic [1:0] sizeCode;
  } strobe_t;

  typedef struct packed {
    logic              valid;
    logic              err;
    logic              swapOk;
    logic [DATA_W-1:0] data;
  } rsp_t;

  function automatic logic [DATA_W-1:0] lowMask(logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    lowMask = 64'h0000_0000_0000_00FF;
      2'd1:    lowMask = 64'h0000_0000_0000_FFFF;
      2'd2:    lowMask = 64'h0000_0000_FFFF_FFFF;
      default: lowMask = '1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] laneSpan(logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    laneSpan = 8'h01;
      2'd1:    laneSpan = 8'h03;
      2'd2:    laneSpan = 8'h0F;
      default: laneSpan = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/atomic_swap_mem_ctrl.sv
module atomic_swap_mem_ctrl
  import atomic_swap_mem_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 'h100,
  parameter int              DEPTH  = 32,
  parameter int              IDX_W  = 5
) (
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqCond,
  output strobe_t           strobe,
  output logic [IDX_W-1:0]  wordIdx
);

  localparam int WIN_BYTES = DEPTH * LANES;
  localparam logic [ADDR_W+1:0] WIN_END = (ADDR_W+2)'(WIN_BYTES);

  op_e opCode;
  assign opCode = op_e'(reqOp);

  // Offset from the window base; the top bit is the borrow.
  logic [ADDR_W:0]   offsetExt;
  logic [ADDR_W+1:0] endExt;
  logic [3:0]        byteCount;
  logic [2:0]        alignMask;
  logic              belowBase, aboveTop, misaligned, narrowCond, fault;

  assign offsetExt = {1'b0, reqAddr} - {1'b0, BASE};
  assign byteCount = 4'd1 << reqSize;
  assign endExt    = {1'b0, offsetExt} + (ADDR_W+2)'(byteCount);
  assign belowBase = offsetExt[ADDR_W];
  assign aboveTop  = endExt > WIN_END;

  always_comb begin
    case (reqSize)
      2'd0:    alignMask = 3'b000;
      2'd1:    alignMask = 3'b001;
      2'd2:    alignMask = 3'b011;
      default: alignMask = 3'b111;
    endcase
  end

  assign misaligned = |(reqAddr[2:0] & alignMask);
  assign narrowCond = (opCode == OP_SWAP) && reqCond && (reqSize < 2'd2);
  assign fault      = belowBase || aboveTop || misaligned || narrowCond;

  always_comb begin
    strobe          = '0;
    strobe.valid    = reqValid;
    strobe.err      = reqValid && fault;
    strobe.load     = reqValid && !fault && (opCode == OP_READ || opCode == OP_SWAP);
    strobe.store    = reqValid && !fault && (opCode == OP_WRITE || opCode == OP_SWAP);
    strobe.isSwap   = reqValid && (opCode == OP_SWAP);
    strobe.cmpGate  = reqValid && !fault && (opCode == OP_SWAP) && reqCond;
    strobe.laneOff  = offsetExt[2:0];
    strobe.sizeCode = reqSize;
  end

  assign wordIdx = offsetExt[IDX_W+2:3];

endmodule

// File: rtl/atomic_swap_mem_dp.sv
module atomic_swap_mem_dp
  import atomic_swap_mem_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int IDX_W     = 5,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cmpData,
  output logic              wrEn,
  output rsp_t              rspNext
);

  logic [DATA_W-1:0] memArr [DEPTH];

  logic [DATA_W-1:0] oldWord, oldVal, sizeMsk, wShift, mergedWord;
  logic [LANES-1:0]  laneEn;
  logic [5:0]        bitOff;
  logic              cmpHit;

  assign oldWord = memArr[wordIdx];
  assign bitOff  = {strobe.laneOff, 3'b000};
  assign sizeMsk = lowMask(strobe.sizeCode);
  assign oldVal  = (oldWord >> bitOff) & sizeMsk;
  assign cmpHit  = oldVal == (cmpData & sizeMsk);
  assign wrEn    = strobe.store && (!strobe.cmpGate || cmpHit);
  assign laneEn  = laneSpan(strobe.sizeCode) << strobe.laneOff;
  assign wShift  = wdata << bitOff;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mergedWord[8*g +: 8] = laneEn[g] ? wShift[8*g +: 8] : oldWord[8*g +: 8];
  end

  if (ZERO_INIT) begin : g_zero
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
      end else if (wrEn) begin
        memArr[wordIdx] <= mergedWord;
      end
    end
  end else begin : g_raw
    always_ff @(posedge clk) begin
      if (wrEn) memArr[wordIdx] <= mergedWord;
    end
  end

  always_comb begin
    rspNext        = '0;
    rspNext.valid  = strobe.valid;
    rspNext.err    = strobe.err;
    rspNext.swapOk = strobe.isSwap && wrEn;
    rspNext.data   = strobe.load ? oldVal : '0;
  end

endmodule

// File: rtl/atomic_swap_mem_pipe.sv
module atomic_swap_mem_pipe
  import atomic_swap_mem_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rstN,
  input  rsp_t rspIn,
  output rsp_t rspOut
);

  rsp_t stage [LATENCY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LATENCY; i++) stage[i] <= '0;
    end else begin
      stage[0] <= rspIn;
      for (int i = 1; i < LATENCY; i++) stage[i] <= stage[i-1];
    end
  end

  assign rspOut = stage[LATENCY-1];

endmodule

// File: rtl/atomic_swap_mem.sv
module atomic_swap_mem
  import atomic_swap_mem_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE      = 'h100,
  parameter int                DEPTH     = 32,
  parameter int                LATENCY   = 3,
  parameter bit                ZERO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  input  logic [63:0]       reqCmp,
  input  logic              reqCond,
  output logic              rspValid,
  output logic [63:0]       rspRdata,
  output logic              rspErr,
  output logic              rspSwapOk
);

  localparam int IDX_W = $clog2(DEPTH);

  strobe_t          strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             memWrEn;
  logic             ctrlErr;
  rsp_t             rspNext, rspOut;

  atomic_swap_mem_ctrl #(
    .ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) i_ctrl (
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqCond(reqCond),
    .strobe(strobe), .wordIdx(wordIdx)
  );

  atomic_swap_mem_dp #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .ZERO_INIT(ZERO_INIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wdata(reqWdata), .cmpData(reqCmp), .wrEn(memWrEn), .rspNext(rspNext)
  );

  atomic_swap_mem_pipe #(.LATENCY(LATENCY)) i_pipe (
    .clk(clk), .rstN(rstN), .rspIn(rspNext), .rspOut(rspOut)
  );

  assign ctrlErr   = strobe.err;
  assign rspValid  = rspOut.valid;
  assign rspRdata  = rspOut.data;
  assign rspErr    = rspOut.err;
  assign rspSwapOk = rspOut.swapOk;

endmodule

// File: rtl/atomic_swap_mem_chk.sv
module atomic_swap_mem_chk #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'h100
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              reqCond,
  input logic              rspValid,
  input logic [63:0]       rspRdata,
  input logic              rspErr,
  input logic              rspSwapOk,
  input logic              ctrlErr,
  input logic              memWrEn
);

  // R11
  err_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspRdata == 64'd0) && !rspSwapOk);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspErr && !rspSwapOk && (rspRdata == 64'd0));

  // R7
  narrow_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd3 && reqCond && reqSize < 2'd2) |-> ctrlErr && !memWrEn);

  // R8
  inval_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd2) |-> !memWrEn);

  // R2
  read_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd0) |-> !memWrEn);

  // R1
  below_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> reqValid && (reqAddr >= BASE));

  // R3
  misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3 && reqAddr[2:0] != 3'd0) |-> ctrlErr && !memWrEn);

endmodule

bind atomic_swap_mem atomic_swap_mem_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .reqSize(reqSize), .reqCond(reqCond), .rspValid(rspValid), .rspRdata(rspRdata),
  .rspErr(rspErr), .rspSwapOk(rspSwapOk), .ctrlErr(ctrlErr), .memWrEn(memWrEn)
);

// File: tb/test_atomic_swap_mem.sv
`timescale 1ns/1ps
module test_atomic_swap_mem;

  localparam int          ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h0100;
  localparam int          DEPTH  = 32;
  localparam int          LAT    = 3;
  localparam int          WIN    = DEPTH * 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] reqAddr = 16'd0;
  logic [1:0]  reqSize = 2'd0;
  logic [63:0] reqWdata = 64'd0;
  logic [63:0] reqCmp = 64'd0;
  logic        reqCond = 1'b0;
  logic        rspValid, rspErr, rspSwapOk;
  logic [63:0] rspRdata;
  string       curTag = "R9";

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  atomic_swap_mem #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH), .LATENCY(LAT), .ZERO_INIT(1'b1))
  i_atomic_swap_mem (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqCmp(reqCmp), .reqCond(reqCond),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr), .rspSwapOk(rspSwapOk)
  );

  // Behavioural reference: byte array plus a delay line of expected responses.
  logic [7:0]  mdl [WIN];
  logic        expV [LAT];
  logic        expE [LAT];
  logic        expOk [LAT];
  logic [63:0] expD [LAT];
  string       expTag [LAT];

  function automatic logic [63:0] mdlRead(int off, int nb);
    logic [63:0] v = 64'd0;
    for (int b = 0; b < nb; b++) v[8*b +: 8] = mdl[off+b];
    return v;
  endfunction

  function automatic logic [63:0] byteMask(int nb);
    logic [63:0] m = 64'd0;
    for (int b = 0; b < nb; b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN; i++) mdl[i] = 8'h00;
      for (int i = 0; i < LAT; i++) begin
        expV[i] = 0; expE[i] = 0; expOk[i] = 0; expD[i] = 0; expTag[i] = "R11";
      end
    end else begin
      int nb, off;
      logic err, ok;
      logic [63:0] data, old;
      for (int i = LAT-1; i > 0; i--) begin
        expV[i] = expV[i-1]; expE[i] = expE[i-1]; expOk[i] = expOk[i-1];
        expD[i] = expD[i-1]; expTag[i] = expTag[i-1];
      end
      nb = 1 << reqSize;
      off = int'(reqAddr) - int'(BASE);
      err = (off < 0) || (off + nb > WIN) || ((int'(reqAddr) % nb) != 0) ||
            (reqOp == 2'd3 && reqCond && reqSize < 2'd2);
      data = 64'd0; ok = 1'b0;
      if (reqValid && !err) begin
        case (reqOp)
          2'd0: data = mdlRead(off, nb);
          2'd1: for (int b = 0; b < nb; b++) mdl[off+b] = reqWdata[8*b +: 8];
          2'd3: begin
            old = mdlRead(off, nb);
            if (!reqCond || old == (reqCmp & byteMask(nb))) begin
              for (int b = 0; b < nb; b++) mdl[off+b] = reqWdata[8*b +: 8];
              ok = 1'b1;
            end
            data = old;
          end
          default: ;
        endcase
      end
      expV[0] = reqValid; expE[0] = reqValid && err; expOk[0] = reqValid && ok;
      expD[0] = reqValid ? data : 64'd0; expTag[0] = curTag;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if (rspValid !== expV[LAT-1]) begin
        miscompares++;
        $display("FAIL R9 rspValid actual=%0b expected=%0b", rspValid, expV[LAT-1]);
      end else if (rspErr !== expE[LAT-1] || rspSwapOk !== expOk[LAT-1] || rspRdata !== expD[LAT-1]) begin
        miscompares++;
        $display("FAIL %s err/ok/data actual=%0b/%0b/%h expected=%0b/%0b/%h", expTag[LAT-1],
                 rspErr, rspSwapOk, rspRdata, expE[LAT-1], expOk[LAT-1], expD[LAT-1]);
      end
    end
  end

  task automatic issue(string tag, logic [1:0] op, logic [15:0] addr, logic [1:0] sz,
                       logic [63:0] wd, logic [63:0] cp, logic cond);
    @(negedge clk);
    curTag = tag; reqValid = 1'b1; reqOp = op; reqAddr = addr; reqSize = sz;
    reqWdata = wd; reqCmp = cp; reqCond = cond;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet while reset is held
    vectors++;
    if (rspValid !== 1'b0 || rspErr !== 1'b0 || rspSwapOk !== 1'b0 || rspRdata !== 64'd0) begin
      miscompares++;
      $display("FAIL R11 reset outputs actual=%0b/%0b/%0b/%h expected=0/0/0/0",
               rspValid, rspErr, rspSwapOk, rspRdata);
    end
    rstN = 1'b1;
    idle(2);

    // R10: fresh array reads as zero
    for (int i = 0; i < 4; i++) issue("R10", 2'd0, BASE + 16'(i*64), 2'd3, 64'd0, 64'd0, 1'b0);
    issue("R10", 2'd0, BASE + 16'hF8, 2'd3, 64'd0, 64'd0, 1'b0);
    idle(LAT);

    // R2: every size, read back at several sizes
    issue("R2", 2'd1, BASE + 16'h00, 2'd3, 64'h0807_0605_0403_0201, 0, 0);
    issue("R2", 2'd1, BASE + 16'h08, 2'd2, 64'hFFFF_FFFF_A1B2_C3D4, 0, 0);
    issue("R2", 2'd1, BASE + 16'h0E, 2'd1, 64'h0000_0000_0000_BEEF, 0, 0);
    issue("R2", 2'd1, BASE + 16'h0D, 2'd0, 64'h0000_0000_0000_0077, 0, 0);
    issue("R2", 2'd0, BASE + 16'h00, 2'd3, 0, 0, 0);
    issue("R2", 2'd0, BASE + 16'h04, 2'd2, 0, 0, 0);
    issue("R2", 2'd0, BASE + 16'h02, 2'd1, 0, 0, 0);
    issue("R2", 2'd0, BASE + 16'h07, 2'd0, 0, 0, 0);
    issue("R2", 2'd0, BASE + 16'h08, 2'd3, 0, 0, 0);
    idle(LAT);

    // R4: byte writes keep neighbours
    issue("R4", 2'd1, BASE + 16'h20, 2'd3, 64'h1111_1111_1111_1111, 0, 0);
    issue("R4", 2'd1, BASE + 16'h23, 2'd0, 64'h0000_0000_0000_00AA, 0, 0);
    issue("R4", 2'd1, BASE + 16'h26, 2'd1, 64'h0000_0000_0000_5566, 0, 0);
    issue("R4", 2'd0, BASE + 16'h20, 2'd3, 0, 0, 0);
    idle(LAT);

    // R3: misaligned accesses rejected, memory unchanged
    issue("R3", 2'd1, BASE + 16'h21, 2'd1, 64'hDEAD, 0, 0);
    issue("R3", 2'd1, BASE + 16'h22, 2'd2, 64'hDEAD_DEAD, 0, 0);
    issue("R3", 2'd3, BASE + 16'h24, 2'd3, 64'hDEAD, 0, 0);
    issue("R3", 2'd0, BASE + 16'h20, 2'd3, 0, 0, 0);
    idle(LAT);

    // R1: window edges
    issue("R1", 2'd1, BASE - 16'd1, 2'd0, 64'h99, 0, 0);
    issue("R1", 2'd1, BASE - 16'd8, 2'd3, 64'h99, 0, 0);
    issue("R1", 2'd1, BASE + 16'(WIN), 2'd3, 64'h99, 0, 0);
    issue("R1", 2'd1, BASE + 16'(WIN - 8), 2'd3, 64'hCAFE_F00D_0000_0001, 0, 0);
    issue("R1", 2'd0, BASE + 16'(WIN - 8), 2'd3, 0, 0, 0);
    issue("R1", 2'd0, BASE + 16'(WIN - 1), 2'd0, 0, 0, 0);
    issue("R1", 2'd0, 16'hFFF8, 2'd3, 0, 0, 0);
    issue("R1", 2'd0, BASE, 2'd3, 0, 0, 0);
    idle(LAT);

    // R5: unconditional swaps at every size, back-to-back on one address
    issue("R5", 2'd3, BASE + 16'h40, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 0, 0);
    issue("R5", 2'd3, BASE + 16'h40, 2'd3, 64'h1234_5678_9ABC_DEF0, 0, 0);
    issue("R5", 2'd3, BASE + 16'h41, 2'd0, 64'h55, 0, 0);
    issue("R5", 2'd3, BASE + 16'h42, 2'd1, 64'h6677, 0, 0);
    issue("R5", 2'd3, BASE + 16'h44, 2'd2, 64'h8899_AABB, 0, 0);
    issue("R5", 2'd0, BASE + 16'h40, 2'd3, 0, 0, 0);
    idle(LAT);

    // R6: conditional swaps, hits and misses
    issue("R6", 2'd1, BASE + 16'h50, 2'd3, 64'h0000_0010_0000_0020, 0, 0);
    issue("R6", 2'd3, BASE + 16'h50, 2'd2, 64'h0000_0021, 64'h0000_0020, 1);
    issue("R6", 2'd3, BASE + 16'h50, 2'd2, 64'h0000_0099, 64'h0000_0020, 1);
    issue("R6", 2'd3, BASE + 16'h54, 2'd2, 64'h0000_0011, 64'hFFFF_FFFF_0000_0010, 1);
    issue("R6", 2'd3, BASE + 16'h50, 2'd3, 64'h7, 64'h0000_0011_0000_0021, 1);
    issue("R6", 2'd3, BASE + 16'h50, 2'd3, 64'h8, 64'h0000_0011_0000_0021, 1);
    issue("R6", 2'd0, BASE + 16'h50, 2'd3, 0, 0, 0);
    idle(LAT);

    // R7: conditional swap at 1 and 2 bytes rejected
    issue("R7", 2'd3, BASE + 16'h50, 2'd0, 64'hFF, 64'h07, 1);
    issue("R7", 2'd3, BASE + 16'h52, 2'd1, 64'hFFFF, 64'h0, 1);
    issue("R7", 2'd0, BASE + 16'h50, 2'd3, 0, 0, 0);
    idle(LAT);

    // R8: invalidate acknowledged, no change
    issue("R8", 2'd2, BASE + 16'h50, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    issue("R8", 2'd2, BASE + 16'h20, 2'd0, 64'hFF, 0, 1);
    issue("R8", 2'd0, BASE + 16'h50, 2'd3, 0, 0, 0);
    issue("R8", 2'd0, BASE + 16'h20, 2'd3, 0, 0, 0);
    idle(LAT);

    // R9: dense mixed traffic with gaps
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  op = 2'($urandom % 4);
      logic [1:0]  sz = 2'($urandom % 4);
      logic [15:0] ad = 16'h00F0 + 16'($urandom % 288);
      logic        cd = 1'($urandom % 2);
      logic [63:0] cp = {$urandom, $urandom};
      int          nb = 1 << sz;
      int          off;
      if (($urandom % 4) != 0) ad = ad & ~16'(nb - 1);
      off = int'(ad) - int'(BASE);
      if (($urandom % 2) == 0 && off >= 0 && off + nb <= WIN) cp = mdlRead(off, nb);
      issue("R9", op, ad, sz, {$urandom, $urandom}, cp, cd);
      if (($urandom % 5) == 0) idle(1);
    end
    idle(LAT + 2);
    finishRun();
  end

endmodule